// File: doc/BRIEF.md
# Per-Core Interrupt Redistributor Register File

This block holds the memory-mapped registers of one per-core interrupt redistributor. A single access port carries 64-bit reads and writes. Each access has a byte offset and a flag that marks a secure access. The block decodes the offset and updates the addressed register. It returns one response word, or a one-cycle error strobe when no register sits at that offset. The stored fields go straight to the rest of the redistributor: the four control flags, the base pointers of the LPI configuration table and the LPI pending table, the LPI identifier width and the sleep request.

A small two-state machine sequences every access. In `ST_IDLE` the port is ready. An accepted access (transition `ACCEPT`: valid while idle) performs the write and latches the read word and error flag, and the machine enters `ST_RESP`. In `ST_RESP` the response is valid for exactly one cycle and the port is not ready. The machine then returns to `ST_IDLE` (transition `RETIRE`). Writes to the two table bases are masked to page-aligned address fields. The identifier width is clamped to the distributor maximum. The type word is assembled from the core number, the affinity and a last-core flag.

Top module: `rdist_regfile`

## Requirements
- R1: After reset every control flag, both table pointers, the identifier width and the sleep request are zero, `acc_ready` is 1 and `rsp_valid` is 0.
- R2: The control register at offset 0x00 holds four flags at fixed bits: enable-LPI at bit 0, disable-group-0 at bit 1, disable-group-1-nonsecure at bit 2 and disable-group-1-secure at bit 3. A read returns them at those bits, and all other bits read as 0.
- R3: A write to the properties base at offset 0x20 keeps only bits [51:12] of the data as the configuration-table pointer. It takes the identifier width from data bits [4:0]. A read returns the pointer ORed with the width.
- R4: The stored identifier width never exceeds 15; a written value above 15 is stored as 15.
- R5: A write to the pending base at offset 0x28 keeps only bits [51:16] of the data as the pending-table pointer. A read returns that pointer.
- R6: A read of the type register at offset 0x10 returns the affinity in [63:32], 1 at bit 24, the core number in [23:8], 1 at bit 5, the last-core flag at bit 4, 1 at bit 3, 1 at bit 0, and zeros elsewhere.
- R7: The last-core flag is 1 only when the core number equals the core count minus one.
- R8: The wake register at offset 0x18 stores a sleep request from data bit 1. A read returns the request at bits 1 and 2. When the access is non-secure and `dist_no_security` is 0, the register reads as zero and the write is ignored.
- R9: The synchronize register (offset 0x30) and the identification register (offset 0x08) read as zero.
- R10: An access to any other offset reads as zero, changes no register and raises `rsp_err` for the single response cycle.
- R11: An access is accepted when `acc_valid` and `acc_ready` are both 1. `rsp_valid` is 1 for exactly the next cycle, and `acc_ready` is 0 during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | OFF_W | Byte offset of the register |
| acc_wdata | input | 64 | Write data |
| acc_secure | input | 1 | Access is secure |
| dist_no_security | input | 1 | Distributor runs with security disabled |
| core_num | input | CORE_W | Number of this core |
| core_count | input | CORE_W+1 | Number of cores in the system |
| core_affinity | input | AFF_W | Affinity value of this core |
| acc_ready | output | 1 | Port can accept an access |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 64 | Read word (zero for writes) |
| rsp_err | output | 1 | Unmapped offset strobe |
| lpi_enable | output | 1 | Enable-LPI flag |
| grp0_disable | output | 1 | Disable-group-0 flag |
| grp1ns_disable | output | 1 | Disable-group-1-nonsecure flag |
| grp1s_disable | output | 1 | Disable-group-1-secure flag |
| cfg_tbl_ptr | output | 64 | Configuration-table pointer |
| pend_tbl_ptr | output | 64 | Pending-table pointer |
| lpi_id_width | output | 5 | Clamped LPI identifier width |
| pe_sleep | output | 1 | Sleep request |

## Verification
The base registers are written with all-ones data and with scattered address patterns. All-ones data shows that both masks remove every bit outside their field. The scattered patterns show that the field boundaries sit at bit 12 and bit 16, not at some nearby bit. The width field is written with 9, 16 and 31, which separates pass-through from the clamp edge. The type word is read with two core counts, so that a constant last-core flag is caught. The wake register is exercised through all three combinations of the secure flag and the security-disable input.

// File: rtl/rdist_pkg.sv
package rdist_pkg;
    typedef enum logic [2:0] {
        REG_CTRL, REG_IDENT, REG_TYPE, REG_WAKE,
        REG_PROPS, REG_PEND, REG_SYNC, REG_NONE
    } reg_sel_t;

    typedef enum logic [0:0] {ST_IDLE, ST_RESP} acc_state_t;

    localparam logic [15:0] OFS_CTRL  = 16'h0000;
    localparam logic [15:0] OFS_IDENT = 16'h0008;
    localparam logic [15:0] OFS_TYPE  = 16'h0010;
    localparam logic [15:0] OFS_WAKE  = 16'h0018;
    localparam logic [15:0] OFS_PROPS = 16'h0020;
    localparam logic [15:0] OFS_PEND  = 16'h0028;
    localparam logic [15:0] OFS_SYNC  = 16'h0030;
endpackage

// File: rtl/rdist_decode.sv
module rdist_decode
    import rdist_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic [OFF_W-1:0] offset,
    output reg_sel_t         sel
);
    always_comb begin
        unique case (offset)
            OFF_W'(OFS_CTRL):  sel = REG_CTRL;
            OFF_W'(OFS_IDENT): sel = REG_IDENT;
            OFF_W'(OFS_TYPE):  sel = REG_TYPE;
            OFF_W'(OFS_WAKE):  sel = REG_WAKE;
            OFF_W'(OFS_PROPS): sel = REG_PROPS;
            OFF_W'(OFS_PEND):  sel = REG_PEND;
            OFF_W'(OFS_SYNC):  sel = REG_SYNC;
            default:           sel = REG_NONE;
        endcase
    end
endmodule

// File: rtl/rdist_type_word.sv
module rdist_type_word #(
    parameter int CORE_W = 16,
    parameter int AFF_W  = 32
) (
    input  logic [CORE_W-1:0] core_num,
    input  logic [CORE_W:0]   core_count,
    input  logic [AFF_W-1:0]  core_affinity,
    output logic [63:0]       type_word
);
    logic is_last;

    always_comb begin
        is_last   = ({1'b0, core_num} == (core_count - 1'b1));
        type_word = '0;
        type_word[32 +: AFF_W]  = core_affinity;
        type_word[24]           = 1'b1;
        type_word[8 +: CORE_W]  = core_num;
        type_word[5]            = 1'b1;
        type_word[4]            = is_last;
        type_word[3]            = 1'b1;
        type_word[0]            = 1'b1;
    end
endmodule

// File: rtl/rdist_fields.sv
module rdist_fields
    import rdist_pkg::*;
#(
    parameter int PA_HI   = 51,
    parameter int CFG_LO  = 12,
    parameter int PEND_LO = 16,
    parameter int ID_MAX  = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_t    sel,
    input  logic [63:0] wdata,
    input  logic        wake_blocked,
    output logic        lpi_enable,
    output logic        grp0_disable,
    output logic        grp1ns_disable,
    output logic        grp1s_disable,
    output logic [63:0] cfg_tbl_ptr,
    output logic [63:0] pend_tbl_ptr,
    output logic [4:0]  lpi_id_width,
    output logic        pe_sleep
);
    localparam logic [63:0] PA_MASK   = (64'd1 << (PA_HI + 1)) - 64'd1;
    localparam logic [63:0] CFG_MASK  = PA_MASK & ~((64'd1 << CFG_LO) - 64'd1);
    localparam logic [63:0] PEND_MASK = PA_MASK & ~((64'd1 << PEND_LO) - 64'd1);
    localparam logic [4:0]  WIDTH_CAP = 5'(ID_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lpi_enable     <= 1'b0;
            grp0_disable   <= 1'b0;
            grp1ns_disable <= 1'b0;
            grp1s_disable  <= 1'b0;
            cfg_tbl_ptr    <= '0;
            pend_tbl_ptr   <= '0;
            lpi_id_width   <= '0;
            pe_sleep       <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                REG_CTRL: begin
                    lpi_enable     <= wdata[0];
                    grp0_disable   <= wdata[1];
                    grp1ns_disable <= wdata[2];
                    grp1s_disable  <= wdata[3];
                end
                REG_PROPS: begin
                    cfg_tbl_ptr  <= wdata & CFG_MASK;
                    lpi_id_width <= (wdata[4:0] > WIDTH_CAP) ? WIDTH_CAP : wdata[4:0];
                end
                REG_PEND: pend_tbl_ptr <= wdata & PEND_MASK;
                REG_WAKE: if (!wake_blocked) pe_sleep <= wdata[1];
                default: ;
            endcase
        end
    end

    // R3: the stored pointer follows the masked write data
    a_r3_cfg_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_PROPS) |=> (cfg_tbl_ptr == ($past(wdata) & CFG_MASK)));
    // R4: width clamp
    a_r4_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_id_width <= WIDTH_CAP);
    // R5: the stored pending pointer follows the masked write data
    a_r5_pend_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_PEND) |=> (pend_tbl_ptr == ($past(wdata) & PEND_MASK)));
    // R8: a blocked wake write leaves the sleep request alone
    a_r8_wake_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_WAKE && wake_blocked) |=> $stable(pe_sleep));
endmodule

// File: rtl/rdist_regfile.sv
module rdist_regfile
    import rdist_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int CORE_W  = 16,
    parameter int AFF_W   = 32,
    parameter int PA_HI   = 51,
    parameter int CFG_LO  = 12,
    parameter int PEND_LO = 16,
    parameter int ID_MAX  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFF_W-1:0]  acc_offset,
    input  logic [63:0]       acc_wdata,
    input  logic              acc_secure,
    input  logic              dist_no_security,
    input  logic [CORE_W-1:0] core_num,
    input  logic [CORE_W:0]   core_count,
    input  logic [AFF_W-1:0]  core_affinity,
    output logic              acc_ready,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              lpi_enable,
    output logic              grp0_disable,
    output logic              grp1ns_disable,
    output logic              grp1s_disable,
    output logic [63:0]       cfg_tbl_ptr,
    output logic [63:0]       pend_tbl_ptr,
    output logic [4:0]        lpi_id_width,
    output logic              pe_sleep
);
    acc_state_t state_q, state_d;
    reg_sel_t   sel;
    logic       accept, wake_blocked;
    logic [63:0] type_word, rd_word;

    rdist_decode #(.OFF_W(OFF_W)) u_decode (.offset(acc_offset), .sel(sel));

    rdist_type_word #(.CORE_W(CORE_W), .AFF_W(AFF_W)) u_type (
        .core_num(core_num), .core_count(core_count),
        .core_affinity(core_affinity), .type_word(type_word));

    rdist_fields #(.PA_HI(PA_HI), .CFG_LO(CFG_LO), .PEND_LO(PEND_LO), .ID_MAX(ID_MAX)) u_fields (
        .clk(clk), .rst_n(rst_n), .wr_en(accept && acc_write), .sel(sel),
        .wdata(acc_wdata), .wake_blocked(wake_blocked),
        .lpi_enable(lpi_enable), .grp0_disable(grp0_disable),
        .grp1ns_disable(grp1ns_disable), .grp1s_disable(grp1s_disable),
        .cfg_tbl_ptr(cfg_tbl_ptr), .pend_tbl_ptr(pend_tbl_ptr),
        .lpi_id_width(lpi_id_width), .pe_sleep(pe_sleep));

    assign wake_blocked = !dist_no_security && !acc_secure;
    assign accept       = acc_valid && (state_q == ST_IDLE);

    // next state: ACCEPT moves to ST_RESP, RETIRE returns to ST_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (acc_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // read word composition
    always_comb begin
        rd_word = '0;
        unique case (sel)
            REG_CTRL:  rd_word[3:0] = {grp1s_disable, grp1ns_disable, grp0_disable, lpi_enable};
            REG_TYPE:  rd_word = type_word;
            REG_WAKE:  if (!wake_blocked) rd_word[2:1] = {pe_sleep, pe_sleep};
            REG_PROPS: rd_word = cfg_tbl_ptr | {59'd0, lpi_id_width};
            REG_PEND:  rd_word = pend_tbl_ptr;
            default:   rd_word = '0;
        endcase
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else if (accept) begin
            rsp_rdata <= acc_write ? 64'd0 : rd_word;
            rsp_err   <= (sel == REG_NONE);
        end else begin
            rsp_err   <= 1'b0;
        end
    end

    assign acc_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);

    // R11: a response lasts one cycle
    a_r11_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R11: an accepted access yields a response next cycle
    a_r11_accept_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> rsp_valid);
    // R10: the error strobe only appears with a response
    a_r10_err_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
endmodule

// File: tb/rdist_regfile_test.sv
module rdist_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_secure = 1'b0, dist_no_security = 1'b0;
    logic [11:0] acc_offset = '0;
    logic [63:0] acc_wdata = '0;
    logic [15:0] core_num = 16'd5;
    logic [16:0] core_count = 17'd8;
    logic [31:0] core_affinity = 32'hA5A5_1234;
    logic        acc_ready, rsp_valid, rsp_err;
    logic [63:0] rsp_rdata, cfg_tbl_ptr, pend_tbl_ptr;
    logic        lpi_enable, grp0_disable, grp1ns_disable, grp1s_disable, pe_sleep;
    logic [4:0]  lpi_id_width;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [63:0] got_rd;
    logic        got_err;

    always #10 clk = ~clk;

    rdist_regfile uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] ofs, input logic [63:0] d, input logic sec);
        @(negedge clk);
        chk("R11 ready before access", {63'd0, acc_ready}, 64'd1);
        acc_valid = 1'b1; acc_write = wr; acc_offset = ofs; acc_wdata = d; acc_secure = sec;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R11 response valid", {63'd0, rsp_valid}, 64'd1);
        chk("R11 not ready in response", {63'd0, acc_ready}, 64'd0);
        got_rd = rsp_rdata; got_err = rsp_err;
        @(negedge clk);
        chk("R11 response one cycle", {63'd0, rsp_valid}, 64'd0);
        chk("R10 error strobe one cycle", {63'd0, rsp_err}, 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 lpi_enable", {63'd0, lpi_enable}, 0);
        chk("R1 flags", {60'd0, grp0_disable, grp1ns_disable, grp1s_disable, pe_sleep}, 0);
        chk("R1 cfg ptr", cfg_tbl_ptr, 0);
        chk("R1 pend ptr", pend_tbl_ptr, 0);
        chk("R1 width", {59'd0, lpi_id_width}, 0);
        chk("R1 ready", {63'd0, acc_ready}, 1);
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 0);
    endtask

    task automatic t_ctrl;
        access(1, 12'h000, 64'hFFFF_FFFF_FFFF_FFF5, 0);
        chk("R2 flag outputs", {60'd0, grp1s_disable, grp1ns_disable, grp0_disable, lpi_enable}, 64'h5);
        access(0, 12'h000, 0, 0);
        chk("R2 ctrl read", got_rd, 64'h5);
        access(1, 12'h000, 64'hA, 0);
        access(0, 12'h000, 0, 0);
        chk("R2 ctrl read alt", got_rd, 64'hA);
    endtask

    task automatic t_props;
        access(1, 12'h020, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        chk("R3 cfg mask all ones", cfg_tbl_ptr, 64'h000F_FFFF_FFFF_F000);
        chk("R4 width clamp 31", {59'd0, lpi_id_width}, 64'd15);
        access(1, 12'h020, 64'h0000_0001_2345_6FE9, 0);
        chk("R3 cfg mask scattered", cfg_tbl_ptr, 64'h0000_0001_2345_6000);
        chk("R3 width pass 9", {59'd0, lpi_id_width}, 64'd9);
        access(0, 12'h020, 0, 0);
        chk("R3 props read", got_rd, 64'h0000_0001_2345_6009);
        access(1, 12'h020, 64'h10, 0);
        chk("R4 width clamp 16", {59'd0, lpi_id_width}, 64'd15);
        access(1, 12'h020, 64'h0F, 0);
        chk("R4 width 15 kept", {59'd0, lpi_id_width}, 64'd15);
    endtask

    task automatic t_pend;
        access(1, 12'h028, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        chk("R5 pend mask all ones", pend_tbl_ptr, 64'h000F_FFFF_FFFF_0000);
        access(1, 12'h028, 64'h0000_0003_0001_8000, 0);
        access(0, 12'h028, 0, 0);
        chk("R5 pend read scattered", got_rd, 64'h0000_0003_0001_0000);
    endtask

    task automatic t_type;
        core_count = 17'd8;
        access(0, 12'h010, 0, 0);
        chk("R6 type word", got_rd, {32'hA5A5_1234, 7'd0, 1'b1, 16'd5, 2'd0, 1'b1, 1'b0, 1'b1, 3'b001});
        core_count = 17'd6;
        access(0, 12'h010, 0, 0);
        chk("R7 last core flag", got_rd, {32'hA5A5_1234, 7'd0, 1'b1, 16'd5, 2'd0, 1'b1, 1'b1, 1'b1, 3'b001});
    endtask

    task automatic t_wake;
        dist_no_security = 1'b0;
        access(1, 12'h018, 64'h2, 0);
        chk("R8 blocked write ignored", {63'd0, pe_sleep}, 0);
        access(1, 12'h018, 64'h2, 1);
        chk("R8 secure write", {63'd0, pe_sleep}, 1);
        access(0, 12'h018, 0, 1);
        chk("R8 secure read", got_rd, 64'h6);
        access(0, 12'h018, 0, 0);
        chk("R8 blocked read zero", got_rd, 64'h0);
        access(1, 12'h018, 64'h0, 0);
        chk("R8 blocked clear ignored", {63'd0, pe_sleep}, 1);
        dist_no_security = 1'b1;
        access(0, 12'h018, 0, 0);
        chk("R8 no-security read", got_rd, 64'h6);
        access(1, 12'h018, 64'h0, 0);
        chk("R8 no-security write", {63'd0, pe_sleep}, 0);
    endtask

    task automatic t_zero_regs;
        access(0, 12'h030, 0, 0);
        chk("R9 sync zero", got_rd, 0);
        chk("R9 sync no err", {63'd0, got_err}, 0);
        access(0, 12'h008, 0, 0);
        chk("R9 ident zero", got_rd, 0);
    endtask

    task automatic t_unmapped;
        logic [63:0] cfg_before, pend_before;
        cfg_before = cfg_tbl_ptr; pend_before = pend_tbl_ptr;
        access(1, 12'h038, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        chk("R10 write err", {63'd0, got_err}, 1);
        chk("R10 cfg unchanged", cfg_tbl_ptr, cfg_before);
        chk("R10 pend unchanged", pend_tbl_ptr, pend_before);
        access(0, 12'h000, 0, 0);
        chk("R10 ctrl unchanged", got_rd, 64'hA);
        access(0, 12'h004, 0, 1);
        chk("R10 read err", {63'd0, got_err}, 1);
        chk("R10 read zero", got_rd, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_props();
        t_pend();
        t_type();
        t_wake();
        t_zero_regs();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule